// File: doc/BRIEF.md
# Clock Manager Relock Supervisor

This block runs on a free-running reference clock and watches a clock-synthesis unit (a DLL or PLL) through its lock output, a bundle of failure status bits and a clock-loss flag. When the unit is unhealthy, the block holds it in reset for a fixed number of cycles. It then gives the unit a fixed window in which to lock. If lock has not been proven by the end of that window, it resets the unit again, and it keeps doing so until lock returns. A single reset pulse is not enough. If the input clock is still missing when the pulse ends, that reset is wasted, and the unit could otherwise sit unlocked forever.

Lock is accepted only after the lock output has been high for several consecutive cycles, with no failure bit set and the loss flag low. A low loss flag on its own never counts as proof of a clock. A floating input can pick up a neighbouring clock and hide the loss, so the block waits for lock itself.

A saturating counter records how many lock windows expired. A sticky fault flag rises once that count reaches a threshold. A one-cycle event flag marks each successful entry into the locked state. All status pins are plain levels or pulses. There is no streaming data path and so no handshake.

Top module: `relock_ctrl`

## Requirements
- R1: While rst_n is low, mgr_rst is 1, and in_lock, relock_evt, fault and retry_cnt are all 0.
- R2: While in_lock is 1, any set bit of mgr_fail, a high mgr_clk_lost or a low mgr_locked seen at a clock edge makes mgr_rst rise at the second following edge. The condition is registered once and then moves the sequencer. When the inputs show no problem, in_lock stays 1.
- R3: Every reset pulse after the first one following rst_n lasts exactly RST_W cycles.
- R4: If lock is not accepted, a new reset pulse starts exactly RST_W+LOCK_WAIT cycles after the previous one started. This repeats without limit.
- R5: Lock is accepted only after LOCK_CHECKS consecutive registered samples in the wait window that show mgr_locked high, mgr_clk_lost low and mgr_fail all zero. A low mgr_clk_lost with mgr_locked low never leads to lock.
- R6: relock_evt is high for exactly one cycle, namely the first cycle in which in_lock is 1.
- R7: retry_cnt rises by one on each expired lock window and on nothing else, so a reset caused by loss of lock does not change it. It saturates at 2^CNT_W-1 and keeps its value while locked.
- R8: fault becomes 1 in the same cycle that retry_cnt reaches MAX_RETRY. It stays 1 through any later lock and is cleared only by rst_n.
- R9: mgr_rst is never 1 while in_lock is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, independent of the managed unit |
| rst_n | input | 1 | Active-low synchronous reset |
| mgr_locked | input | 1 | Lock output of the clock-synthesis unit |
| mgr_fail | input | FAIL_W | Failure status bits of the unit, ORed together |
| mgr_clk_lost | input | 1 | Input-clock-loss flag of the unit |
| mgr_rst | output | 1 | Reset to the clock-synthesis unit, registered |
| in_lock | output | 1 | High while lock is accepted |
| relock_evt | output | 1 | One-cycle pulse on each entry into lock |
| retry_cnt | output | CNT_W | Saturating count of expired lock windows |
| fault | output | 1 | Sticky flag: retry_cnt reached MAX_RETRY |

## Verification
The bench pins down the two-edge latency from a failure input to the reset pin. A design that drives the reset straight from the inputs, or adds a stage, misses that cycle. It sends a clock-loss flag that stays low while lock never comes. A design that trusts the flag alone would report lock, and a design that stops after one reset would stop pulsing. It gives a lock that flickers in runs shorter than the qualification count, which a design accepting the first high sample would lock on. It also counts many expired windows, so that a counter that wraps instead of saturating, or a fault flag that clears on relock, shows up at the ports.

// File: rtl/relock_pkg.sv
package relock_pkg;
  typedef enum logic [1:0] {
    ST_PULSE  = 2'd0,
    ST_WAIT   = 2'd1,
    ST_LOCKED = 2'd2
  } relock_state_e;
endpackage

// File: rtl/relock_detect.sv
module relock_detect #(
  parameter int FAIL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic [FAIL_W-1:0] fail,
  input  logic              lost,
  output logic              bad_q
);
  // Any failure source, OR-reduced and captured in one flop
  logic any_fail;
  always_comb any_fail = (|fail) | lost | ~locked;

  always_ff @(posedge clk) begin
    if (!rst_n) bad_q <= 1'b1;
    else        bad_q <= any_fail;
  end
endmodule

// File: rtl/relock_seq.sv
module relock_seq
  import relock_pkg::*;
#(
  parameter int RST_W       = 4,
  parameter int LOCK_WAIT   = 1024,
  parameter int LOCK_CHECKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_q,
  output logic mgr_rst,
  output logic in_lock,
  output logic relock_evt,
  output logic timeout
);
  localparam int TMAX = (RST_W > LOCK_WAIT) ? RST_W : LOCK_WAIT;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int QW   = $clog2(LOCK_CHECKS + 1);
  localparam logic [TW-1:0] PULSE_LAST = TW'(RST_W - 1);
  localparam logic [TW-1:0] WAIT_LAST  = TW'(LOCK_WAIT - 1);
  localparam logic [QW-1:0] RUN_LAST   = QW'(LOCK_CHECKS - 1);

  relock_state_e state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [QW-1:0] run_q, run_d;
  logic          evt_q, evt_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    run_d   = run_q;
    evt_d   = 1'b0;
    timeout = 1'b0;
    case (state_q)
      ST_PULSE: begin
        if (tmr_q == PULSE_LAST) begin
          state_d = ST_WAIT;
          tmr_d   = '0;
          run_d   = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (!bad_q && run_q == RUN_LAST) begin
          state_d = ST_LOCKED;
          evt_d   = 1'b1;
        end else begin
          run_d = bad_q ? '0 : run_q + 1'b1;
          if (tmr_q == WAIT_LAST) begin
            state_d = ST_PULSE;
            tmr_d   = '0;
            timeout = 1'b1;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end
      end
      ST_LOCKED: begin
        if (bad_q) begin
          state_d = ST_PULSE;
          tmr_d   = '0;
        end
      end
      default: begin
        state_d = ST_PULSE;
        tmr_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PULSE;
      tmr_q   <= '0;
      run_q   <= '0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      run_q   <= run_d;
      evt_q   <= evt_d;
    end
  end

  assign mgr_rst    = (state_q == ST_PULSE);
  assign in_lock    = (state_q == ST_LOCKED);
  assign relock_evt = evt_q;
endmodule

// File: rtl/relock_retry.sv
module relock_retry #(
  parameter int CNT_W     = 4,
  parameter int MAX_RETRY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timeout,
  output logic [CNT_W-1:0] retry_cnt,
  output logic             fault
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fault_q;
  logic             at_limit;

  always_comb begin
    cnt_d    = (timeout && cnt_q != CNT_TOP) ? cnt_q + 1'b1 : cnt_q;
    at_limit = ({{(32-CNT_W){1'b0}}, cnt_d} >= 32'(MAX_RETRY));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fault_q <= fault_q | (timeout & at_limit);
    end
  end

  assign retry_cnt = cnt_q;
  assign fault     = fault_q;
endmodule

// File: rtl/relock_ctrl.sv
module relock_ctrl #(
  parameter int FAIL_W      = 4,
  parameter int RST_W       = 4,
  parameter int LOCK_WAIT   = 1024,
  parameter int LOCK_CHECKS = 4,
  parameter int CNT_W       = 4,
  parameter int MAX_RETRY   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgr_locked,
  input  logic [FAIL_W-1:0] mgr_fail,
  input  logic              mgr_clk_lost,
  output logic              mgr_rst,
  output logic              in_lock,
  output logic              relock_evt,
  output logic [CNT_W-1:0]  retry_cnt,
  output logic              fault
);
  logic bad_q;
  logic timeout;

  relock_detect #(.FAIL_W(FAIL_W)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .locked (mgr_locked),
    .fail   (mgr_fail),
    .lost   (mgr_clk_lost),
    .bad_q  (bad_q)
  );

  relock_seq #(
    .RST_W       (RST_W),
    .LOCK_WAIT   (LOCK_WAIT),
    .LOCK_CHECKS (LOCK_CHECKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bad_q      (bad_q),
    .mgr_rst    (mgr_rst),
    .in_lock    (in_lock),
    .relock_evt (relock_evt),
    .timeout    (timeout)
  );

  relock_retry #(
    .CNT_W     (CNT_W),
    .MAX_RETRY (MAX_RETRY)
  ) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .timeout   (timeout),
    .retry_cnt (retry_cnt),
    .fault     (fault)
  );
endmodule

// File: rtl/relock_ctrl_chk.sv
module relock_ctrl_chk #(
  parameter int FAIL_W = 4,
  parameter int RST_W  = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mgr_locked,
  input logic [FAIL_W-1:0] mgr_fail,
  input logic              mgr_clk_lost,
  input logic              mgr_rst,
  input logic              in_lock,
  input logic              relock_evt,
  input logic [CNT_W-1:0]  retry_cnt,
  input logic              fault
);
  localparam logic [CNT_W-1:0] TOP = '1;

  int   hi_cnt;
  logic rst_prev;
  logic seen_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt    <= 0;
      rst_prev  <= 1'b1;
      seen_fall <= 1'b0;
    end else begin
      hi_cnt    <= mgr_rst ? hi_cnt + 1 : 0;
      rst_prev  <= mgr_rst;
      seen_fall <= seen_fall | (rst_prev & ~mgr_rst);
    end
  end

  p_exit_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lock && (!mgr_locked || mgr_clk_lost || (|mgr_fail))) |=> ##1 mgr_rst);

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_fall && rst_prev && !mgr_rst) |-> (hi_cnt == RST_W));

  p_evt_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_lock) |-> relock_evt);

  p_evt_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    relock_evt |=> !relock_evt);

  p_evt_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    relock_evt |-> in_lock);

  p_retry_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt != $past(retry_cnt)) |-> (retry_cnt == $past(retry_cnt) + 1'b1));

  p_retry_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt == TOP) |=> (retry_cnt == TOP));

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  p_lock_norst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_lock |-> !mgr_rst);
endmodule

bind relock_ctrl relock_ctrl_chk #(
  .FAIL_W (FAIL_W),
  .RST_W  (RST_W),
  .CNT_W  (CNT_W)
) u_relock_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mgr_locked   (mgr_locked),
  .mgr_fail     (mgr_fail),
  .mgr_clk_lost (mgr_clk_lost),
  .mgr_rst      (mgr_rst),
  .in_lock      (in_lock),
  .relock_evt   (relock_evt),
  .retry_cnt    (retry_cnt),
  .fault        (fault)
);

// File: tb/test_relock_ctrl.sv
module test_relock_ctrl;
  localparam int FAIL_W = 4;
  localparam int RST_W = 4;
  localparam int LOCK_WAIT = 32;
  localparam int LOCK_CHECKS = 3;
  localparam int CNT_W = 3;
  localparam int MAX_RETRY = 3;
  localparam int RESP_DLY = 5;
  localparam int CNT_TOP = (1 << CNT_W) - 1;

  // vector: {expect_rst, lock, lost, fail[3:0]}
  localparam int NV = 7;
  localparam logic [6:0] VEC [NV] = '{
    7'b0_1_0_0000, 7'b1_1_0_0001, 7'b1_1_0_1000, 7'b1_1_0_0110,
    7'b1_1_1_0000, 7'b1_0_0_0000, 7'b0_1_0_0000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_present = 1'b1;
  logic ovr_en = 1'b0, ovr_lock = 1'b0, ovr_lost = 1'b0;
  logic [FAIL_W-1:0] fail_drv = '0;
  logic resp_lock;
  int   resp_cnt;
  logic mgr_locked, mgr_clk_lost, mgr_rst, in_lock, relock_evt, fault;
  logic [CNT_W-1:0] retry_cnt;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  // behavioural lock responder
  always_ff @(posedge clk) begin
    if (mgr_rst || !src_present) begin
      resp_cnt  <= 0;
      resp_lock <= 1'b0;
    end else begin
      if (resp_cnt < RESP_DLY) resp_cnt <= resp_cnt + 1;
      resp_lock <= (resp_cnt >= RESP_DLY);
    end
  end

  assign mgr_locked   = ovr_en ? ovr_lock : resp_lock;
  assign mgr_clk_lost = ovr_en ? ovr_lost : ~src_present;

  relock_ctrl #(
    .FAIL_W(FAIL_W), .RST_W(RST_W), .LOCK_WAIT(LOCK_WAIT),
    .LOCK_CHECKS(LOCK_CHECKS), .CNT_W(CNT_W), .MAX_RETRY(MAX_RETRY)
  ) i_relock_ctrl (
    .clk(clk), .rst_n(rst_n), .mgr_locked(mgr_locked), .mgr_fail(fail_drv),
    .mgr_clk_lost(mgr_clk_lost), .mgr_rst(mgr_rst), .in_lock(in_lock),
    .relock_evt(relock_evt), .retry_cnt(retry_cnt), .fault(fault)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_lock(input string req);
    for (int i = 0; i < 400; i++) begin
      if (in_lock) break;
      tick();
    end
    chk(in_lock, req, int'(in_lock), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int width, k, cyc, last_rise, exp_r;
    bit saw, prev;
    repeat (3) tick();
    // R1 reset state
    chk(mgr_rst == 1'b1, "R1 mgr_rst", int'(mgr_rst), 1);
    chk(!in_lock && !relock_evt, "R1 lock/evt", int'(in_lock), 0);
    chk(retry_cnt == 0 && !fault, "R1 retry/fault", int'(retry_cnt), 0);
    rst_n = 1'b1;

    // R6 normal lock and event pulse
    wait_lock("R6 first lock");
    chk(relock_evt == 1'b1, "R6 evt on entry", int'(relock_evt), 1);
    tick();
    chk(!relock_evt && in_lock, "R6 evt single", int'(relock_evt), 0);
    chk(retry_cnt == 0, "R7 no retry on quick lock", int'(retry_cnt), 0);

    // R2/R3/R9 failure vectors
    for (int v = 0; v < NV; v++) begin
      wait_lock("R2 relock");
      ovr_en = 1'b1; ovr_lock = VEC[v][5]; ovr_lost = VEC[v][4]; fail_drv = VEC[v][3:0];
      tick();
      chk(mgr_rst == 1'b0, "R2 no reset after one edge", int'(mgr_rst), 0);
      ovr_en = 1'b0; fail_drv = '0;
      tick();
      chk(mgr_rst == VEC[v][6], "R2 reset after two edges", int'(mgr_rst), int'(VEC[v][6]));
      if (VEC[v][6]) begin
        width = 0;
        while (mgr_rst && width < 100) begin width++; tick(); end
        chk(width == RST_W, "R3 pulse width", width, RST_W);
      end else begin
        chk(in_lock == 1'b1, "R9 lock held when quiet", int'(in_lock), 1);
      end
    end
    wait_lock("R2 final relock");
    chk(retry_cnt == 0, "R7 loss pulses do not count", int'(retry_cnt), 0);

    // R5 loss flag low but no lock, then flickering lock
    ovr_en = 1'b1; ovr_lost = 1'b0; ovr_lock = 1'b0;
    repeat (4) tick();
    saw = 1'b0;
    for (int i = 0; i < 80; i++) begin tick(); saw |= in_lock; end
    chk(!saw, "R5 low loss flag alone", int'(saw), 0);
    saw = 1'b0;
    for (int i = 0; i < 120; i++) begin
      ovr_lock = ((i % 4) < 2);
      tick();
      saw |= in_lock;
    end
    chk(!saw, "R5 short lock runs", int'(saw), 0);
    ovr_lock = 1'b1;
    for (int i = 0; i < RST_W + LOCK_WAIT + 8; i++) begin
      if (in_lock) break;
      tick();
    end
    chk(in_lock, "R5 steady lock accepted", int'(in_lock), 1);

    // R4/R7/R8 repeated timeouts after a fresh reset
    rst_n = 1'b0; ovr_lock = 1'b0; ovr_lost = 1'b0;
    repeat (2) tick();
    chk(fault == 1'b0 && retry_cnt == 0, "R8 reset clears", int'(fault), 0);
    rst_n = 1'b1;
    prev = mgr_rst; k = 0; cyc = 0; last_rise = -1;
    while (k < 10 && cyc < 1000) begin
      tick();
      cyc++;
      if (mgr_rst && !prev) begin
        k++;
        if (last_rise >= 0)
          chk(cyc - last_rise == RST_W + LOCK_WAIT, "R4 retry period", cyc - last_rise, RST_W + LOCK_WAIT);
        last_rise = cyc;
        exp_r = (k > CNT_TOP) ? CNT_TOP : k;
        chk(int'(retry_cnt) == exp_r, "R7 retry count", int'(retry_cnt), exp_r);
        chk(fault == (k >= MAX_RETRY), "R8 fault threshold", int'(fault), int'(k >= MAX_RETRY));
      end
      prev = mgr_rst;
    end
    chk(k == 10, "R4 retries keep coming", k, 10);

    ovr_en = 1'b0; src_present = 1'b1;
    wait_lock("R8 relock after fault");
    chk(fault == 1'b1, "R8 fault sticky", int'(fault), 1);
    chk(int'(retry_cnt) == CNT_TOP, "R7 count holds in lock", int'(retry_cnt), CNT_TOP);

    rst_n = 1'b0;
    repeat (2) tick();
    chk(fault == 1'b0, "R8 cleared by rst_n", int'(fault), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule